// File: doc/BRIEF.md
# Clock Generator Power Sequencer

This block is the control state machine of a two-output clock generator. A master oscillator feeds a prescaler that produces the reference output, and a divider behind the prescaler produces the main output. The block decides when the oscillator runs and when the master clock is gated. It also decides when the prescaler and divider are held at their largest ratios, when the divider counters are held in reset, and when each output is driven, enabled or released to high impedance. It runs the same orderly sequence after a power-on reset and after a power-down request is withdrawn. When a request arrives, it takes the outputs down one at a time, in an order that cuts no pulse short.

On startup the ratios are forced to their maximum. The block waits for the output enable to go high and then counts 256 cycles while the oscillator settles. It then loads the programmed ratios, drives the reference output if the configuration allows it, and enables the main output last. A power-down request passes through a synchronizer. The block first disables the main output and holds the divider in reset, then waits for the main output to be seen low before releasing it to high impedance. It next stops the master clock and the reference output, and it stops the oscillator last. The programmed ratios come in on plain configuration inputs.

Top module: `clkseq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the block keeps the oscillator stopped and the master clock gated. Both outputs are disabled and in high impedance, and the divider is held in reset. The effective ratio reads the maximum, which is prescaler code 2'b10 (divide by 4) and divider value N_MAX.
- R2: `pwrdn_n` passes through two flops before the sequencer acts on it. After it falls, the outputs keep their values for two rising edges and change at the third.
- R3: With the output enable high, a startup holds `force_max` high for exactly 257 cycles: one warm-up cycle and then a stabilization wait of 256 counted cycles. The effective ratio reads code 2'b10 and N_MAX during the wait.
- R4: The stabilization wait begins only at the first rising edge that sees `oe` high. While `oe` stays low the block stays in warm-up, with `force_max` high and the reference output disabled. A low `oe` after the wait has begun does not lengthen it, so the wait lasts 256 cycles.
- R5: `load_ratio` pulses for exactly one cycle right after the wait, and `force_max` is low in that cycle. From the next cycle the effective ratio equals `cfg_m_sel`/`cfg_n`.
- R6: The cycle after the load pulse drives the reference output (`ref_en`=1, `ref_hiz`=0) while the main output stays in high impedance. The cycle after that enables and drives the main output.
- R7: With `cfg_ref_on` low, the reference output stays disabled and in high impedance through the whole sequence.
- R8: The first shutdown step drops `main_en` and raises `div_rst` while still driving the main output. The block stays in this step for as long as `main_lvl` is high.
- R9: One cycle after `main_lvl` is seen low, the main output goes to high impedance. The next cycle disables the reference output, puts it in high impedance and gates the master clock. The cycle after that stops the oscillator.
- R10: A power-down request that arrives during the startup wait abandons the startup and enters the shutdown path.
- R11: If the request is withdrawn during shutdown, the shutdown still runs to the oscillator-off step. Only from that step does the block return to warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrdn_n | input | 1 | Power-down request, active low, asynchronous |
| oe | input | 1 | Output enable level |
| main_lvl | input | 1 | Observed level of the main output |
| cfg_ref_on | input | 1 | Reference output allowed by configuration |
| cfg_m_sel | input | 2 | Programmed prescaler code: 00 /1, 01 /2, 10 /4 |
| cfg_n | input | N_W | Programmed divider value |
| osc_run | output | 1 | Oscillator run |
| mclk_en | output | 1 | Master clock gate enable |
| force_max | output | 1 | Hold prescaler and divider at maximum ratio |
| div_rst | output | 1 | Divider counter reset |
| load_ratio | output | 1 | One-cycle strobe that loads the programmed ratios |
| ref_en | output | 1 | Reference output enable |
| ref_hiz | output | 1 | Reference output high impedance |
| main_en | output | 1 | Main output enable |
| main_hiz | output | 1 | Main output high impedance |
| eff_m_sel | output | 2 | Effective prescaler code |
| eff_n | output | N_W | Effective divider value |

## Verification
The bench counts the startup wait cycle by cycle. A counter that stopped one short, or restarted on an `oe` glitch, would change the 257 and 256 totals. It holds the main output high through the first shutdown step, so a design that tri-stated the output without waiting would cut a pulse short. It withdraws the request in the middle of a shutdown to catch a sequencer that turned back before the oscillator-off step. It also requests power-down during the wait, and it runs a startup with `oe` low, where a design that did not stall would start the reference output anyway.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   localparam logic [1:0] M_DIV1 = 2'b00;
   localparam logic [1:0] M_DIV2 = 2'b01;
   localparam logic [1:0] M_DIV4 = 2'b10;
   localparam logic [1:0] M_MAX  = M_DIV4;

   typedef enum logic [3:0] {
      ST_INIT    = 4'd0,
      ST_WARM    = 4'd1,
      ST_STAB    = 4'd2,
      ST_LOAD    = 4'd3,
      ST_REFON   = 4'd4,
      ST_RUN     = 4'd5,
      ST_DNMAIN  = 4'd6,
      ST_DNMAINZ = 4'd7,
      ST_DNREF   = 4'd8,
      ST_OFF     = 4'd9
   } seq_state_t;

   typedef struct packed {
      logic osc_run;
      logic mclk_en;
      logic force_max;
      logic div_rst;
      logic load_ratio;
      logic ref_en;
      logic ref_hiz;
      logic main_en;
      logic main_hiz;
   } seq_ctl_t;

   function automatic seq_ctl_t seq_decode(seq_state_t st, logic ref_on);
      seq_ctl_t c;
      logic     ref_live;
      c = '{osc_run: 1'b0, mclk_en: 1'b0, force_max: 1'b0, div_rst: 1'b1,
            load_ratio: 1'b0, ref_en: 1'b0, ref_hiz: 1'b1, main_en: 1'b0,
            main_hiz: 1'b1};
      ref_live = 1'b0;
      case (st)
         ST_WARM, ST_STAB: begin
            c.osc_run   = 1'b1;
            c.mclk_en   = 1'b1;
            c.force_max = 1'b1;
            c.div_rst   = 1'b0;
         end
         ST_LOAD: begin
            c.osc_run    = 1'b1;
            c.mclk_en    = 1'b1;
            c.div_rst    = 1'b0;
            c.load_ratio = 1'b1;
         end
         ST_REFON: begin
            c.osc_run = 1'b1;
            c.mclk_en = 1'b1;
            c.div_rst = 1'b0;
            ref_live  = 1'b1;
         end
         ST_RUN: begin
            c.osc_run  = 1'b1;
            c.mclk_en  = 1'b1;
            c.div_rst  = 1'b0;
            c.main_en  = 1'b1;
            c.main_hiz = 1'b0;
            ref_live   = 1'b1;
         end
         ST_DNMAIN: begin
            c.osc_run  = 1'b1;
            c.mclk_en  = 1'b1;
            c.main_hiz = 1'b0;
            ref_live   = 1'b1;
         end
         ST_DNMAINZ: begin
            c.osc_run = 1'b1;
            c.mclk_en = 1'b1;
            ref_live  = 1'b1;
         end
         ST_DNREF: begin
            c.osc_run = 1'b1;
         end
         default: begin
         end
      endcase
      c.ref_en  = ref_live & ref_on;
      c.ref_hiz = ~(ref_live & ref_on);
      return c;
   endfunction

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_in};
      end
   end

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/clkseq_stab_cnt.sv
module clkseq_stab_cnt #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);

   localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("clkseq_stab_cnt: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (cnt_q != TERM) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == TERM) && !clr;

   // R3
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/clkseq_ratio.sv
module clkseq_ratio
   import clkseq_pkg::*;
#(
   parameter int N_W   = 10,
   parameter int N_MAX = 513
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           force_max,
   input  logic           load,
   input  logic [1:0]     cfg_m_sel,
   input  logic [N_W-1:0] cfg_n,
   output logic [1:0]     m_sel,
   output logic [N_W-1:0] n_val
);

   localparam logic [N_W-1:0] N_TOP = N_W'(N_MAX);

   generate
      if (N_MAX < 1 || N_MAX >= (1 << N_W)) begin : g_bad_nmax
         $error("clkseq_ratio: N_MAX must fit in N_W bits");
      end
   endgenerate

   logic [1:0]     m_q;
   logic [N_W-1:0] n_q;
   logic [1:0]     m_cfg_legal;

   always_comb begin
      m_cfg_legal = (cfg_m_sel == 2'b11) ? M_MAX : cfg_m_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= M_MAX;
         n_q <= N_TOP;
      end else if (load) begin
         m_q <= m_cfg_legal;
         n_q <= cfg_n;
      end else if (force_max) begin
         m_q <= M_MAX;
         n_q <= N_TOP;
      end
   end

   assign m_sel = m_q;
   assign n_val = n_q;

   // R5
   ratio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (n_val == $past(cfg_n)));

endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
   import clkseq_pkg::*;
#(
   parameter int N_W         = 10,
   parameter int N_MAX       = 513,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwrdn_n,
   input  logic           oe,
   input  logic           main_lvl,
   input  logic           cfg_ref_on,
   input  logic [1:0]     cfg_m_sel,
   input  logic [N_W-1:0] cfg_n,
   output logic           osc_run,
   output logic           mclk_en,
   output logic           force_max,
   output logic           div_rst,
   output logic           load_ratio,
   output logic           ref_en,
   output logic           ref_hiz,
   output logic           main_en,
   output logic           main_hiz,
   output logic [1:0]     eff_m_sel,
   output logic [N_W-1:0] eff_n
);

   generate
      if (N_W < 2) begin : g_bad_nw
         $error("clkseq_ctrl: N_W must be at least 2");
      end
   endgenerate

   seq_state_t state_q, state_d;
   seq_ctl_t   ctl;
   logic       pwrdn_sync;
   logic       pd_req;
   logic       stab_done;
   logic       stab_clr;

   clkseq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) pd_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pwrdn_n),
      .q_out (pwrdn_sync)
   );

   assign pd_req   = ~pwrdn_sync;
   assign stab_clr = (state_q != ST_STAB);

   clkseq_stab_cnt #(
      .CNT_W (CNT_W)
   ) stab_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stab_clr),
      .done  (stab_done)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_INIT:    state_d = ST_WARM;
         ST_WARM:    state_d = pd_req ? ST_DNMAIN : (oe ? ST_STAB : ST_WARM);
         ST_STAB:    state_d = pd_req ? ST_DNMAIN : (stab_done ? ST_LOAD : ST_STAB);
         ST_LOAD:    state_d = pd_req ? ST_DNMAIN : ST_REFON;
         ST_REFON:   state_d = pd_req ? ST_DNMAIN : ST_RUN;
         ST_RUN:     state_d = pd_req ? ST_DNMAIN : ST_RUN;
         ST_DNMAIN:  state_d = main_lvl ? ST_DNMAIN : ST_DNMAINZ;
         ST_DNMAINZ: state_d = ST_DNREF;
         ST_DNREF:   state_d = ST_OFF;
         ST_OFF:     state_d = pd_req ? ST_OFF : ST_WARM;
         default:    state_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
      end else begin
         state_q <= state_d;
      end
   end

   always_comb begin
      ctl = seq_decode(state_q, cfg_ref_on);
   end

   assign osc_run    = ctl.osc_run;
   assign mclk_en    = ctl.mclk_en;
   assign force_max  = ctl.force_max;
   assign div_rst    = ctl.div_rst;
   assign load_ratio = ctl.load_ratio;
   assign ref_en     = ctl.ref_en;
   assign ref_hiz    = ctl.ref_hiz;
   assign main_en    = ctl.main_en;
   assign main_hiz   = ctl.main_hiz;

   clkseq_ratio #(
      .N_W   (N_W),
      .N_MAX (N_MAX)
   ) ratio_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_max (ctl.force_max),
      .load      (ctl.load_ratio),
      .cfg_m_sel (cfg_m_sel),
      .cfg_n     (cfg_n),
      .m_sel     (eff_m_sel),
      .n_val     (eff_n)
   );

   // R4
   warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WARM && !oe && !pd_req) |=> (state_q == ST_WARM));

   // R6
   main_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_en) |-> $past(load_ratio, 2));

   // R8
   main_hiz_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_hiz) |-> !$past(main_lvl));

   // R9
   osc_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_run) |-> (!$past(mclk_en) && $past(ref_hiz)));

   // R11
   off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_run) |-> !$past(mclk_en));

endmodule

// File: tb/clkseq_ctrl_tb_top.sv
module clkseq_ctrl_tb_top;

   localparam int N_W   = 10;
   localparam int N_MAX = 513;

   localparam logic [8:0] E_OFF    = 9'b000100101;
   localparam logic [8:0] E_WARM   = 9'b111000101;
   localparam logic [8:0] E_LOAD   = 9'b110010101;
   localparam logic [8:0] E_REF    = 9'b110001001;
   localparam logic [8:0] E_RUN    = 9'b110001010;
   localparam logic [8:0] E_DNMAIN = 9'b110101000;
   localparam logic [8:0] E_DNMZ   = 9'b110101001;
   localparam logic [8:0] E_DNREF  = 9'b100100101;

   // {pwrdn_n, main_lvl, oe, cycles[1:0], expected[8:0]}
   localparam int NVEC = 9;
   localparam logic [13:0] VEC [0:NVEC-1] = '{
      {1'b0, 1'b1, 1'b1, 2'd1, E_RUN},
      {1'b0, 1'b1, 1'b1, 2'd1, E_RUN},
      {1'b0, 1'b1, 1'b1, 2'd1, E_DNMAIN},
      {1'b0, 1'b1, 1'b1, 2'd3, E_DNMAIN},
      {1'b0, 1'b0, 1'b1, 2'd1, E_DNMZ},
      {1'b1, 1'b0, 1'b1, 2'd1, E_DNREF},
      {1'b1, 1'b0, 1'b1, 2'd1, E_OFF},
      {1'b1, 1'b0, 1'b1, 2'd1, E_WARM},
      {1'b1, 1'b0, 1'b1, 2'd1, E_WARM}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           pwrdn_n = 1'b1;
   logic           oe = 1'b1;
   logic           main_lvl = 1'b0;
   logic           cfg_ref_on = 1'b1;
   logic [1:0]     cfg_m_sel = 2'b01;
   logic [N_W-1:0] cfg_n = 10'd37;
   logic           osc_run, mclk_en, force_max, div_rst, load_ratio;
   logic           ref_en, ref_hiz, main_en, main_hiz;
   logic [1:0]     eff_m_sel;
   logic [N_W-1:0] eff_n;
   wire  [8:0]     outs = {osc_run, mclk_en, force_max, div_rst, load_ratio,
                           ref_en, ref_hiz, main_en, main_hiz};

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   clkseq_ctrl #(.N_W(N_W), .N_MAX(N_MAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .oe(oe),
      .main_lvl(main_lvl), .cfg_ref_on(cfg_ref_on), .cfg_m_sel(cfg_m_sel),
      .cfg_n(cfg_n), .osc_run(osc_run), .mclk_en(mclk_en),
      .force_max(force_max), .div_rst(div_rst), .load_ratio(load_ratio),
      .ref_en(ref_en), .ref_hiz(ref_hiz), .main_en(main_en),
      .main_hiz(main_hiz), .eff_m_sel(eff_m_sel), .eff_n(eff_n)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic count_force(output int fm_cnt);
      fm_cnt = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (load_ratio) break;
         if (force_max) fm_cnt++;
      end
   endtask

   initial begin
      int fm;
      int saw_load;
      #12;
      @(negedge clk);
      chk("R1 outputs in reset", outs, E_OFF);
      chk("R1 ratio code in reset", eff_m_sel, 2'b10);
      chk("R1 divider in reset", eff_n, N_MAX);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle after reset", outs, E_WARM);
      count_force(fm);
      chk("R3 force_max cycles at startup", fm + 1, 257);
      chk("R3 ratio code during wait", eff_m_sel, 2'b10);
      chk("R5 load strobe outputs", outs, E_LOAD);
      @(negedge clk);
      chk("R6 reference driven first", outs, E_REF);
      chk("R5 programmed code applied", eff_m_sel, 2'b01);
      chk("R5 programmed divider applied", eff_n, 10'd37);
      @(negedge clk);
      chk("R6 main enabled", outs, E_RUN);

      // table walk: R2 R8 R9 R11
      for (int v = 0; v < NVEC; v++) begin
         pwrdn_n  = VEC[v][13];
         main_lvl = VEC[v][12];
         oe       = VEC[v][11];
         for (int c = 0; c < int'(VEC[v][10:9]); c++) @(negedge clk);
         chk($sformatf("R2 R8 R9 R11 table row %0d", v), outs, VEC[v][8:0]);
      end

      // R10: request during the stabilization wait
      repeat (20) @(negedge clk);
      pwrdn_n  = 1'b0;
      main_lvl = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 abort into shutdown", outs, E_DNMAIN);
      repeat (3) @(negedge clk);
      chk("R10 shutdown completes", outs, E_OFF);

      // R4: stall while oe low
      oe = 1'b0;
      pwrdn_n = 1'b1;
      saw_load = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (load_ratio || ref_en) saw_load = 1;
      end
      chk("R4 held in warm-up with oe low", outs, E_WARM);
      chk("R4 no load or reference with oe low", saw_load, 0);
      oe = 1'b1;
      fork
         begin
            repeat (10) @(negedge clk);
            oe = 1'b0;
         end
      join_none
      count_force(fm);
      chk("R4 wait not stretched by oe drop", fm, 256);
      oe = 1'b1;

      // R7: reference disabled by configuration
      rst_n = 1'b0;
      cfg_ref_on = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run", outs, E_OFF);
      rst_n = 1'b1;
      count_force(fm);
      repeat (2) @(negedge clk);
      chk("R7 reference kept off", {ref_en, ref_hiz}, 2'b01);
      chk("R7 main still enabled", {main_en, main_hiz}, 2'b10);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule